// File: doc/BRIEF.md
# Programmable Chip Select Unit

This unit sits between a bus master and its external memories and peripherals. At the start of each bus cycle it decodes the address and the memory or I/O space indicator against ranges held in its registers. It then asserts at most one chip select and holds that select for the length of the cycle. Six memory selects serve three memory ranges, with two selects per range. Eight peripheral selects each serve one 256-byte block, and the blocks sit next to each other above a common base.

Each select has its own wait-state count and its own ready-enable bit. The unit counts down the programmed wait states and raises its internal ready once the count expires. When the select's ready-enable bit is set, it also waits for the external ready input to be high. Registers are written through a simple indexed write port. After reset, only the upper memory range is live, so the boot code can be fetched.

Top module: `cs_unit`

## Requirements
- R1: After reset no select and no ready are asserted. Ranges 0 and 1 and all peripheral selects are disabled. Range 2 (upper) is enabled with base 0xF0000, size 2^16, 3 wait states and external ready ignored.
- R2: A write with `reg_we_i` high loads register `reg_idx_i`. Indices 0..2 are memory ranges 0..2, index 3 is the peripheral base and indices 4..11 are peripheral controls 0..7. A range word holds base [19:0], size log2 S [24:20], wait count [26:25], ready enable [27] and enable [28]. A peripheral control word uses bits [28:25] in the same way. The peripheral base word holds base [19:0] and space [20], where 1 means I/O.
- R3: An enabled range k with size S (1..20) matches a memory cycle when addr and base agree on all bits from S upward. It drives select 2k when addr[S-1] is 0 and select 2k+1 when addr[S-1] is 1.
- R4: Memory ranges never match I/O cycles (`io_i`=1). The peripheral window matches only cycles whose space equals the space bit.
- R5: Peripheral select i covers base+256*i to base+256*i+255. Addresses below the base, or 2048 or more above it, match no peripheral.
- R6: Peripheral selects take priority over memory selects, and a lower range index wins over a higher one. A disabled select never matches, so a lower-priority match wins instead.
- R7: At most one select is asserted. It appears in the cycle after `cyc_start_i` is sampled, stays steady until ready, and is released in the cycle after ready.
- R8: With external ready ignored, `rdy_o` rises exactly W cycles after the first select cycle, where W is the wait count. A low `ext_rdy_i` then has no effect.
- R9: With external ready enabled, `rdy_o` rises in the first cycle that has at least W waits elapsed and `ext_rdy_i` high.
- R10: A cycle that matches nothing asserts no select and gives ready in its first cycle.
- R11: A register write made during a bus cycle leaves that cycle's timing unchanged and applies from the next cycle.
- R12: `cyc_start_i` is ignored while a cycle is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_start_i | input | 1 | Bus cycle start, address valid |
| addr_i | input | 20 | Bus cycle address |
| io_i | input | 1 | 1 = I/O space, 0 = memory space |
| ext_rdy_i | input | 1 | External ready |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 4 | Register index |
| reg_wdata_i | input | 29 | Register write data |
| mem_cs_o | output | 6 | Memory chip selects, active high |
| per_cs_o | output | 8 | Peripheral chip selects, active high |
| rdy_o | output | 1 | Internal ready, ends the bus cycle |

## Verification
The decoder is tried with addresses on both sides of each range's half bit, so that the two selects of a range are told apart. It also gets addresses just inside and just outside the peripheral window, and the same address in both spaces, which separates memory matching from I/O matching. Overlapping windows (a peripheral over range 0, and range 1 over range 0) show that the priority order holds. Disabling the winner shows that the next match wins. The wait timing is tried with counts 0 to 3. External ready is held low both for fewer and for more cycles than the count, and on selects that honour it as well as on selects that ignore it. Writes issued mid-cycle and starts held high mid-cycle show that neither disturbs a cycle in progress.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int unsigned WS_W = 2;
  localparam int unsigned SZ_W = 5;

  typedef struct packed {
    logic            en;
    logic            rdy_en;
    logic [WS_W-1:0] ws;
  } sel_cfg_t;

  function automatic int unsigned reg_w(int unsigned aw);
    return aw + SZ_W + WS_W + 2;
  endfunction

  function automatic int unsigned idx_w(int unsigned nr, int unsigned np);
    return $clog2(nr + 1 + np);
  endfunction
endpackage

// File: rtl/cs_regs.sv
module cs_regs
  import cs_pkg::*;
#(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned N_RANGE   = 3,
  parameter int unsigned N_PER     = 8,
  parameter int unsigned BOOT_SIZE = 16,
  parameter int unsigned BOOT_WS   = 3
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [idx_w(N_RANGE, N_PER)-1:0]  idx_i,
  input  logic [reg_w(ADDR_W)-1:0]          wdata_i,
  output sel_cfg_t [N_RANGE-1:0]            rng_cfg_o,
  output logic [N_RANGE-1:0][ADDR_W-1:0]    rng_base_o,
  output logic [N_RANGE-1:0][SZ_W-1:0]      rng_size_o,
  output sel_cfg_t [N_PER-1:0]              per_cfg_o,
  output logic [ADDR_W-1:0]                 per_base_o,
  output logic                              per_io_o
);
  localparam int unsigned REG_W   = reg_w(ADDR_W);
  localparam int unsigned IDX_W   = idx_w(N_RANGE, N_PER);
  localparam int unsigned POS_WS  = ADDR_W + SZ_W;
  localparam int unsigned POS_EN  = POS_WS + WS_W + 1;
  localparam int unsigned PB_IDX  = N_RANGE;
  localparam int unsigned PER_IDX = N_RANGE + 1;
  localparam logic [ADDR_W-1:0] BOOT_BASE = {ADDR_W{1'b1}} << BOOT_SIZE;
  localparam logic [REG_W-1:0]  BOOT_WORD =
    {1'b1, 1'b0, WS_W'(BOOT_WS), SZ_W'(BOOT_SIZE), BOOT_BASE};

  for (genvar r = 0; r < N_RANGE; r++) begin : g_rng
    logic [REG_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            word_q <= (r == N_RANGE-1) ? BOOT_WORD : '0;
      else if (we_i && idx_i == IDX_W'(r))    word_q <= wdata_i;
    end
    assign rng_base_o[r] = word_q[ADDR_W-1:0];
    assign rng_size_o[r] = word_q[ADDR_W +: SZ_W];
    assign rng_cfg_o[r]  = sel_cfg_t'(word_q[POS_EN:POS_WS]);
  end

  for (genvar p = 0; p < N_PER; p++) begin : g_per
    sel_cfg_t cfg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  cfg_q <= '0;
      else if (we_i && idx_i == IDX_W'(PER_IDX+p))  cfg_q <= sel_cfg_t'(wdata_i[POS_EN:POS_WS]);
    end
    assign per_cfg_o[p] = cfg_q;
  end

  logic [ADDR_W:0] pbase_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            pbase_q <= '0;
    else if (we_i && idx_i == IDX_W'(PB_IDX)) pbase_q <= wdata_i[ADDR_W:0];
  end
  assign per_base_o = pbase_q[ADDR_W-1:0];
  assign per_io_o   = pbase_q[ADDR_W];

  // Boot range stays live out of reset
  p_boot_live_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> rng_cfg_o[N_RANGE-1].en);
endmodule

// File: rtl/cs_match.sv
module cs_match
  import cs_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned N_RANGE = 3,
  parameter int unsigned N_PER  = 8,
  parameter int unsigned BLK_W  = 8
) (
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic                            io_i,
  input  sel_cfg_t [N_RANGE-1:0]          rng_cfg_i,
  input  logic [N_RANGE-1:0][ADDR_W-1:0]  rng_base_i,
  input  logic [N_RANGE-1:0][SZ_W-1:0]    rng_size_i,
  input  sel_cfg_t [N_PER-1:0]            per_cfg_i,
  input  logic [ADDR_W-1:0]               per_base_i,
  input  logic                            per_io_i,
  output logic [2*N_RANGE+N_PER-1:0]      sel_o,
  output logic [WS_W-1:0]                 ws_o,
  output logic                            rdy_en_o
);
  localparam int unsigned N_MEM  = 2 * N_RANGE;
  localparam int unsigned PIDX_W = (N_PER > 1) ? $clog2(N_PER) : 1;
  localparam logic [31:0] WIN    = 32'(N_PER) << BLK_W;

  logic [N_RANGE-1:0] rng_hit, rng_half;
  logic [N_PER-1:0]   per_hit;

  for (genvar r = 0; r < N_RANGE; r++) begin : g_rng
    logic [SZ_W-1:0]   eff;
    logic [ADDR_W-1:0] hsh;
    assign eff = (rng_size_i[r] > SZ_W'(ADDR_W)) ? SZ_W'(ADDR_W) : rng_size_i[r];
    assign hsh = addr_i >> (eff - SZ_W'(1));
    assign rng_half[r] = hsh[0];
    assign rng_hit[r]  = rng_cfg_i[r].en && !io_i && (eff != '0) &&
                         (((addr_i ^ rng_base_i[r]) >> eff) == '0);
  end

  logic [ADDR_W-1:0] off;
  logic              in_win;
  logic [PIDX_W-1:0] pidx;
  assign off    = addr_i - per_base_i;
  assign in_win = (addr_i >= per_base_i) && (io_i == per_io_i) && (32'(off) < WIN);
  assign pidx   = PIDX_W'(off >> BLK_W);

  for (genvar p = 0; p < N_PER; p++) begin : g_per
    assign per_hit[p] = in_win && (pidx == PIDX_W'(p)) && per_cfg_i[p].en;
  end

  // Fixed priority: peripherals, then ranges by ascending index
  always_comb begin
    logic found;
    found    = 1'b0;
    sel_o    = '0;
    ws_o     = '0;
    rdy_en_o = 1'b0;
    for (int p = 0; p < N_PER; p++) begin
      if (!found && per_hit[p]) begin
        found            = 1'b1;
        sel_o[N_MEM + p] = 1'b1;
        ws_o             = per_cfg_i[p].ws;
        rdy_en_o         = per_cfg_i[p].rdy_en;
      end
    end
    for (int r = 0; r < N_RANGE; r++) begin
      if (!found && rng_hit[r]) begin
        found                    = 1'b1;
        sel_o[2*r + rng_half[r]] = 1'b1;
        ws_o                     = rng_cfg_i[r].ws;
        rdy_en_o                 = rng_cfg_i[r].rdy_en;
      end
    end
  end
endmodule

// File: rtl/cs_seq.sv
module cs_seq
  import cs_pkg::*;
#(
  parameter int unsigned N_SEL = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [N_SEL-1:0] sel_i,
  input  logic [WS_W-1:0]  ws_i,
  input  logic             rdy_en_i,
  input  logic             ext_rdy_i,
  output logic [N_SEL-1:0] cs_o,
  output logic             rdy_o,
  output logic             busy_o
);
  logic             busy_q, rdy_en_q;
  logic [WS_W-1:0]  cnt_q;
  logic [N_SEL-1:0] cs_q;

  assign rdy_o  = busy_q && (cnt_q == '0) && (!rdy_en_q || ext_rdy_i);
  assign cs_o   = cs_q;
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      rdy_en_q <= 1'b0;
      cnt_q    <= '0;
      cs_q     <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q   <= 1'b1;
        cs_q     <= sel_i;
        cnt_q    <= ws_i;
        rdy_en_q <= rdy_en_i;
      end
    end else if (rdy_o) begin
      busy_q <= 1'b0;
      cs_q   <= '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // Checker: cycles elapsed since the select appeared vs. programmed count
  logic [WS_W:0]   chk_el;
  logic [WS_W-1:0] chk_ws;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_el <= '0;
      chk_ws <= '0;
    end else if (!busy_q && start_i) begin
      chk_el <= '0;
      chk_ws <= ws_i;
    end else if (busy_q && chk_el != '1) begin
      chk_el <= chk_el + 1'b1;
    end
  end

  p_min_wait_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> chk_el >= {1'b0, chk_ws});
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !rdy_o |=> $stable(cs_q) && busy_q);
  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |=> cs_q == '0 && !busy_q);
  p_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_q));
  p_start_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q && start_i |=> busy_q);
endmodule

// File: rtl/cs_unit.sv
module cs_unit
  import cs_pkg::*;
#(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned N_RANGE   = 3,
  parameter int unsigned N_PER     = 8,
  parameter int unsigned BLK_W     = 8,
  parameter int unsigned BOOT_SIZE = 16,
  parameter int unsigned BOOT_WS   = 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             cyc_start_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic                             io_i,
  input  logic                             ext_rdy_i,
  input  logic                             reg_we_i,
  input  logic [idx_w(N_RANGE, N_PER)-1:0] reg_idx_i,
  input  logic [reg_w(ADDR_W)-1:0]         reg_wdata_i,
  output logic [2*N_RANGE-1:0]             mem_cs_o,
  output logic [N_PER-1:0]                 per_cs_o,
  output logic                             rdy_o
);
  localparam int unsigned N_MEM = 2 * N_RANGE;
  localparam int unsigned N_SEL = N_MEM + N_PER;

  sel_cfg_t [N_RANGE-1:0]          rng_cfg;
  logic [N_RANGE-1:0][ADDR_W-1:0]  rng_base;
  logic [N_RANGE-1:0][SZ_W-1:0]    rng_size;
  sel_cfg_t [N_PER-1:0]            per_cfg;
  logic [ADDR_W-1:0]               per_base;
  logic                            per_io;
  logic [N_SEL-1:0]                sel, cs;
  logic [WS_W-1:0]                 ws;
  logic                            rdy_en, busy;

  cs_regs #(
    .ADDR_W(ADDR_W), .N_RANGE(N_RANGE), .N_PER(N_PER),
    .BOOT_SIZE(BOOT_SIZE), .BOOT_WS(BOOT_WS)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .idx_i(reg_idx_i), .wdata_i(reg_wdata_i),
    .rng_cfg_o(rng_cfg), .rng_base_o(rng_base), .rng_size_o(rng_size),
    .per_cfg_o(per_cfg), .per_base_o(per_base), .per_io_o(per_io)
  );

  cs_match #(
    .ADDR_W(ADDR_W), .N_RANGE(N_RANGE), .N_PER(N_PER), .BLK_W(BLK_W)
  ) u_match (
    .addr_i, .io_i,
    .rng_cfg_i(rng_cfg), .rng_base_i(rng_base), .rng_size_i(rng_size),
    .per_cfg_i(per_cfg), .per_base_i(per_base), .per_io_i(per_io),
    .sel_o(sel), .ws_o(ws), .rdy_en_o(rdy_en)
  );

  cs_seq #(.N_SEL(N_SEL)) u_seq (
    .clk_i, .rst_ni,
    .start_i(cyc_start_i), .sel_i(sel), .ws_i(ws), .rdy_en_i(rdy_en),
    .ext_rdy_i, .cs_o(cs), .rdy_o, .busy_o(busy)
  );

  assign mem_cs_o = cs[N_MEM-1:0];
  assign per_cs_o = cs[N_SEL-1:N_MEM];

  p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (mem_cs_o == '0) && (per_cs_o == '0) && !rdy_o);
endmodule

// File: tb/tb_cs_unit.sv
module tb_cs_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cyc_start_i = 1'b0;
  logic [19:0] addr_i = '0;
  logic        io_i = 1'b0;
  logic        ext_rdy_i = 1'b1;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_idx_i = '0;
  logic [28:0] reg_wdata_i = '0;
  logic [5:0]  mem_cs_o;
  logic [7:0]  per_cs_o;
  logic        rdy_o;

  int n_cmp = 0;
  int n_err = 0;

  always #4 clk_i = ~clk_i;

  cs_unit dut (.*);

  function automatic logic [28:0] rng_w(bit en, bit re, int ws, int sz, logic [19:0] base);
    return {en, re, 2'(ws), 5'(sz), base};
  endfunction

  function automatic logic [28:0] pb_w(bit io, logic [19:0] base);
    return {8'b0, io, base};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [28:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_idx_i = 4'(idx); reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  // One bus cycle; exp_w = first cycle index at which ready is expected
  task automatic run_cyc(string req, logic [19:0] a, bit io, logic [5:0] em, logic [7:0] ep,
                         int ws, bit re, int k, bit hold = 0, bit mw = 0,
                         int midx = 0, logic [28:0] md = '0);
    int exp_w;
    exp_w = (re && k > ws) ? k : ws;
    @(negedge clk_i);
    cyc_start_i = 1'b1; addr_i = a; io_i = io;
    @(negedge clk_i);
    for (int i = 0; i <= exp_w; i++) begin
      cyc_start_i = hold;
      if (hold) addr_i = a ^ 20'h80000;
      ext_rdy_i = (i >= k);
      reg_we_i = mw && (i == 0);
      reg_idx_i = 4'(midx); reg_wdata_i = md;
      #1;
      chk({req, " mem_cs"}, 32'(mem_cs_o), 32'(em));
      chk({req, " per_cs"}, 32'(per_cs_o), 32'(ep));
      chk({req, " rdy"}, 32'(rdy_o), 32'(i == exp_w));
      if (i < exp_w) @(negedge clk_i);
    end
    @(negedge clk_i);
    cyc_start_i = 1'b0; reg_we_i = 1'b0; ext_rdy_i = 1'b1;
    #1;
    chk({req, " released"}, {mem_cs_o, per_cs_o, rdy_o}, '0);
  endtask

  task automatic t_reset_boot();
    #1;
    chk("R1 reset", {mem_cs_o, per_cs_o, rdy_o}, '0);
    run_cyc("R1 boot lo", 20'hF1234, 0, 6'b010000, 8'h00, 3, 0, 0);
    run_cyc("R1 R8 boot hi ext ignored", 20'hF8000, 0, 6'b100000, 8'h00, 3, 0, 10);
    run_cyc("R4 boot io", 20'hF1234, 1, 6'b0, 8'h00, 0, 0, 0);
    run_cyc("R10 R1 range0 off", 20'h00100, 0, 6'b0, 8'h00, 0, 0, 0);
  endtask

  task automatic t_ranges();
    wr(0, rng_w(1, 1, 1, 14, 20'h00000));
    run_cyc("R3 R9 slow ext", 20'h00100, 0, 6'b000001, 8'h00, 1, 1, 3);
    run_cyc("R9 fast ext", 20'h00100, 0, 6'b000001, 8'h00, 1, 1, 0);
    run_cyc("R3 upper half", 20'h02000, 0, 6'b000010, 8'h00, 1, 1, 0);
    wr(1, rng_w(1, 0, 2, 17, 20'h40000));
    run_cyc("R3 R2 r1 lo", 20'h41000, 0, 6'b000100, 8'h00, 2, 0, 0);
    run_cyc("R3 r1 hi", 20'h5FFFF, 0, 6'b001000, 8'h00, 2, 0, 0);
    run_cyc("R10 beyond r1", 20'h60000, 0, 6'b0, 8'h00, 0, 0, 0);
  endtask

  task automatic t_periph();
    wr(3, pb_w(1, 20'h00400));
    for (int i = 0; i < 8; i++) wr(4 + i, rng_w(1, 0, i % 4, 0, 20'h0));
    run_cyc("R5 per0", 20'h00400, 1, 6'b0, 8'h01, 0, 0, 0);
    run_cyc("R5 per7 top", 20'h00B7F, 1, 6'b0, 8'h80, 3, 0, 0);
    run_cyc("R5 per2", 20'h00680, 1, 6'b0, 8'h04, 2, 0, 0);
    run_cyc("R5 past window", 20'h00C00, 1, 6'b0, 8'h00, 0, 0, 0);
    run_cyc("R5 below base", 20'h003FF, 1, 6'b0, 8'h00, 0, 0, 0);
    run_cyc("R4 mem cycle io window", 20'h00400, 0, 6'b000001, 8'h00, 1, 1, 0);
  endtask

  task automatic t_priority();
    wr(3, pb_w(0, 20'h00400));
    run_cyc("R6 per over mem", 20'h00500, 0, 6'b0, 8'h02, 1, 0, 0);
    wr(5, '0);
    run_cyc("R6 disabled per", 20'h00500, 0, 6'b000001, 8'h00, 1, 1, 0);
    wr(1, rng_w(1, 0, 2, 15, 20'h00000));
    run_cyc("R6 range0 over range1", 20'h00100, 0, 6'b000001, 8'h00, 1, 1, 0);
    run_cyc("R6 range1 only", 20'h05000, 0, 6'b001000, 8'h00, 2, 0, 0);
  endtask

  task automatic t_midwrite();
    run_cyc("R11 old cfg", 20'h00100, 0, 6'b000001, 8'h00, 1, 1, 0, 0, 1, 0,
            rng_w(1, 0, 3, 14, 20'h00000));
    run_cyc("R11 R8 new cfg", 20'h00100, 0, 6'b000001, 8'h00, 3, 0, 10);
  endtask

  task automatic t_hold_start();
    run_cyc("R12 start held", 20'h00100, 0, 6'b000001, 8'h00, 3, 0, 0, 1);
  endtask

  initial begin
    #(8 * 200000);
    n_cmp++; n_err++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset_boot();
    t_ranges();
    t_periph();
    t_priority();
    t_midwrite();
    t_hold_start();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule